// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block is the digital mode sequencer of a step-down converter. It decides whether the power stage runs in fixed-frequency PWM or in a hysteretic burst mode for light loads, and it drives the high-side and low-side switch enables. In PWM mode the switch pattern follows a duty signal from the external PWM comparator. In burst mode the block makes its own pulses. Each pulse keeps the high side on until the inductor peak flag rises, then keeps the low side on until the current reaches zero. Bursts of pulses refill the output into a band that lies wholly at or above the target.

All comparator flags come from asynchronous analog circuits and are resynchronized inside the block. Mode changes take effect only on the boundary of an internal switching-cycle counter. The regulation band runs from the target up to +2.5%. PWM returns only when the output falls below -2%. This asymmetric hysteresis keeps the mode from chattering and keeps undershoot small when the block leaves burst mode.

Top module: `burst_mode_ctrl`

## Requirements
- R1: While reset is held or `enable` is low, both switch enables, `switching` and `modeBurst` are 0. One clock after `enable` goes high, the block is in PWM mode.
- R2: In PWM mode `hsEn` equals `pwmDrive`, `lsEn` equals its inverse, and `switching` is 1.
- R3: Every comparator flag passes through two flip-flops before use. A synchronized light-load flag in PWM mode moves the block to burst mode (`modeBurst`=1) at the next cycle boundary. It then waits idle with both switches off.
- R4: In burst idle, a pulse (`hsEn`=1) starts only when the at-or-below-target flag is set and the upper-band flag is clear. While the upper-band flag is set, idle holds.
- R5: During a burst pulse `hsEn` stays on until the peak-current flag or the burst-limit flag is seen. The high side then turns off and `lsEn` turns on.
- R6: The low side turns off on the zero-current flag. If that flag never comes, it turns off after LS_TIMEOUT clocks.
- R7: When the low-side phase ends, the next pulse starts at once. The exception is when the upper-band flag or the burst-limit flag was seen during the burst; the block then returns to idle.
- R8: Any below-exit flag seen in burst mode, even a short one, is held pending. It returns the block to PWM at the next cycle boundary. While the below-exit flag is set, the light-load flag cannot start burst mode.
- R9: While enabled, `modeBurst` changes only on a cycle boundary (every CYCLE_LEN clocks from reset release).
- R10: `hsEn` and `lsEn` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Regulator enable; low forces both switches off |
| pwmDrive | input | 1 | High-side request from the PWM comparator (PWM mode only) |
| belowExit | input | 1 | Output below target -2% |
| atTarget | input | 1 | Output at or below target |
| aboveUpper | input | 1 | Output at or above target +2.5% |
| lightLoad | input | 1 | Load below the burst threshold |
| peakReached | input | 1 | Inductor current reached the burst peak |
| burstLimit | input | 1 | Burst current limit reached |
| zeroCurrent | input | 1 | Inductor current near zero |
| modeBurst | output | 1 | 1 = burst mode, 0 = PWM |
| hsEn | output | 1 | High-side switch enable |
| lsEn | output | 1 | Low-side switch enable |
| switching | output | 1 | Power stage actively switching |

## Verification
The main collision is between the burst pulse machine and the boundary-gated mode change. A low-side phase can end in the same cycle as a cycle boundary that carries a pending exit; the exit must win, and the block lands in PWM, not in a new pulse. The bench provokes this with a below-exit pulse only two clocks wide, shorter than a cycle, while bursts run. It then judges the result from the mode and switch pattern after the next boundary. It also logs every mode change and checks that the gap between changes is a whole number of cycles.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWM,
    ST_IDLE,
    ST_HIGH,
    ST_LOW
  } bmcState_e;

  // synchronized comparator flags
  typedef struct packed {
    logic belowExit;
    logic atTarget;
    logic aboveUpper;
    logic lightLoad;
    logic peak;
    logic limit;
    logic zero;
  } flagVec_t;

  localparam int unsigned FLAG_W = $bits(flagVec_t);

  // control -> datapath strobes
  typedef struct packed {
    logic lsRun;
  } ctlStrobe_t;

endpackage

// File: rtl/bmc_datapath.sv
module bmc_datapath
  import bmc_pkg::*;
#(
  parameter int unsigned CYCLE_LEN  = 8,
  parameter int unsigned LS_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  flagVec_t   rawFlags,
  input  ctlStrobe_t strobe,
  output flagVec_t   syncFlags,
  output logic       cycEdge,
  output logic       lsTimeout
);

  localparam int unsigned CW = (CYCLE_LEN  > 1) ? $clog2(CYCLE_LEN)    : 1;
  localparam int unsigned LW = (LS_TIMEOUT > 1) ? $clog2(LS_TIMEOUT+1) : 1;

  logic [FLAG_W-1:0] rawBits;
  logic [FLAG_W-1:0] stage1;
  logic [FLAG_W-1:0] stage2;

  assign rawBits = rawFlags;

  // two-flop synchronizer per flag
  for (genvar i = 0; i < FLAG_W; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= rawBits[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign syncFlags = flagVec_t'(stage2);

  // switching-cycle counter
  logic [CW-1:0] cycCnt;
  assign cycEdge = (cycCnt == CW'(CYCLE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cycCnt <= '0;
    else if (cycEdge) cycCnt <= '0;
    else              cycCnt <= cycCnt + 1'b1;
  end

  // low-side phase timer
  logic [LW-1:0] lsCnt;
  assign lsTimeout = (lsCnt == LW'(LS_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.lsRun) lsCnt <= '0;
    else                         lsCnt <= lsCnt + 1'b1;
  end

endmodule

// File: rtl/bmc_control.sv
module bmc_control
  import bmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       pwmDrive,
  input  flagVec_t   syncFlags,
  input  logic       cycEdge,
  input  logic       lsTimeout,
  output ctlStrobe_t strobe,
  output logic       hsEn,
  output logic       lsEn,
  output logic       modeBurst,
  output logic       switching
);

  bmcState_e state, nextState;
  logic exitPend, stopReq;
  logic inBurst;

  assign inBurst = (state == ST_IDLE) || (state == ST_HIGH) || (state == ST_LOW);

  always_comb begin
    nextState = state;
    case (state)
      ST_OFF:  if (enable) nextState = ST_PWM;
      ST_PWM:  if (cycEdge && syncFlags.lightLoad && !syncFlags.belowExit)
                 nextState = ST_IDLE;
      ST_IDLE, ST_HIGH, ST_LOW: begin
        if (cycEdge && (exitPend || syncFlags.belowExit)) begin
          nextState = ST_PWM;
        end else begin
          case (state)
            ST_IDLE: if (syncFlags.atTarget && !syncFlags.aboveUpper)
                       nextState = ST_HIGH;
            ST_HIGH: if (syncFlags.peak || syncFlags.limit)
                       nextState = ST_LOW;
            default: if (syncFlags.zero || lsTimeout)
                       nextState = (stopReq || syncFlags.aboveUpper || syncFlags.limit)
                                   ? ST_IDLE : ST_HIGH;
          endcase
        end
      end
      default: nextState = ST_OFF;
    endcase
    if (!enable) nextState = ST_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      exitPend <= 1'b0;
      stopReq  <= 1'b0;
    end else begin
      state <= nextState;
      if (!inBurst || nextState == ST_PWM || nextState == ST_OFF)
        exitPend <= 1'b0;
      else if (syncFlags.belowExit)
        exitPend <= 1'b1;
      if (state == ST_HIGH || state == ST_LOW) begin
        if (syncFlags.aboveUpper || syncFlags.limit) stopReq <= 1'b1;
      end else begin
        stopReq <= 1'b0;
      end
    end
  end

  always_comb begin
    hsEn      = 1'b0;
    lsEn      = 1'b0;
    switching = 1'b0;
    case (state)
      ST_PWM:  begin hsEn = pwmDrive; lsEn = !pwmDrive; switching = 1'b1; end
      ST_HIGH: begin hsEn = 1'b1; switching = 1'b1; end
      ST_LOW:  begin lsEn = 1'b1; switching = 1'b1; end
      default: ;
    endcase
  end

  assign modeBurst    = inBurst;
  assign strobe.lsRun = (state == ST_LOW);

endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
  import bmc_pkg::*;
#(
  parameter int unsigned CYCLE_LEN  = 8,
  parameter int unsigned LS_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pwmDrive,
  input  logic belowExit,
  input  logic atTarget,
  input  logic aboveUpper,
  input  logic lightLoad,
  input  logic peakReached,
  input  logic burstLimit,
  input  logic zeroCurrent,
  output logic modeBurst,
  output logic hsEn,
  output logic lsEn,
  output logic switching
);

  flagVec_t   rawFlags;
  flagVec_t   syncFlags;
  ctlStrobe_t strobe;
  logic       cycEdge;
  logic       lsTimeout;

  assign rawFlags = '{belowExit:  belowExit,
                      atTarget:   atTarget,
                      aboveUpper: aboveUpper,
                      lightLoad:  lightLoad,
                      peak:       peakReached,
                      limit:      burstLimit,
                      zero:       zeroCurrent};

  bmc_datapath #(.CYCLE_LEN(CYCLE_LEN), .LS_TIMEOUT(LS_TIMEOUT)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rawFlags  (rawFlags),
    .strobe    (strobe),
    .syncFlags (syncFlags),
    .cycEdge   (cycEdge),
    .lsTimeout (lsTimeout)
  );

  bmc_control u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pwmDrive  (pwmDrive),
    .syncFlags (syncFlags),
    .cycEdge   (cycEdge),
    .lsTimeout (lsTimeout),
    .strobe    (strobe),
    .hsEn      (hsEn),
    .lsEn      (lsEn),
    .modeBurst (modeBurst),
    .switching (switching)
  );

endmodule

// File: rtl/bmc_checker.sv
module bmc_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic hsEn,
  input logic lsEn,
  input logic modeBurst,
  input logic cycEdge,
  input logic peakSync,
  input logic upSync
);

  // R1: disable forces both switches off on the next clock
  a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hsEn && !lsEn && !modeBurst));

  // R10: no shoot-through
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsEn && lsEn));

  // R9: entry to burst only after a boundary
  a_r9_entry_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modeBurst) |-> $past(cycEdge));

  // R9: return to PWM while enabled only after a boundary
  a_r9_exit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(modeBurst) && $past(enable)) |-> $past(cycEdge));

  // R5: peak flag ends the high-side phase
  a_r5_peak_release: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBurst && hsEn && peakSync && !cycEdge) |=> !hsEn);

  // R4: upper band holds the idle state
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (modeBurst && !hsEn && !lsEn && upSync && !cycEdge) |=> (!hsEn || !modeBurst));

endmodule

bind burst_mode_ctrl bmc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .hsEn      (hsEn),
  .lsEn      (lsEn),
  .modeBurst (modeBurst),
  .cycEdge   (cycEdge),
  .peakSync  (syncFlags.peak),
  .upSync    (syncFlags.aboveUpper)
);

// File: tb/sim_burst_mode_ctrl.sv
module sim_burst_mode_ctrl;

  localparam int CYC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, pwmDrive = 1'b0;
  logic belowExit = 1'b0, atTarget = 1'b0, aboveUpper = 1'b0, lightLoad = 1'b0;
  logic peakReached = 1'b0, burstLimit = 1'b0, zeroCurrent = 1'b0;
  logic modeBurst, hsEn, lsEn, switching;

  always #2 clk = ~clk;

  burst_mode_ctrl #(.CYCLE_LEN(8), .LS_TIMEOUT(16)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwmDrive(pwmDrive),
    .belowExit(belowExit), .atTarget(atTarget), .aboveUpper(aboveUpper),
    .lightLoad(lightLoad), .peakReached(peakReached), .burstLimit(burstLimit),
    .zeroCurrent(zeroCurrent), .modeBurst(modeBurst), .hsEn(hsEn),
    .lsEn(lsEn), .switching(switching)
  );

  typedef struct {
    logic  hs, ls, mode, sw;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  event doCheck;
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect4(input logic hs, input logic ls, input logic mode,
                         input logic sw, input string tag);
    expItem_t it;
    it.hs = hs; it.ls = ls; it.mode = mode; it.sw = sw; it.tag = tag;
    expQ.push_back(it);
    ->doCheck;
    #0;
  endtask

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      @(doCheck);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if ({hsEn, lsEn, modeBurst, switching} !== {it.hs, it.ls, it.mode, it.sw}) begin
          fails++;
          $display("FAIL %s: hs/ls/mode/sw actual %b%b%b%b expected %b%b%b%b",
                   it.tag, hsEn, lsEn, modeBurst, switching,
                   it.hs, it.ls, it.mode, it.sw);
        end
      end
    end
  end

  // R9 monitor: mode changes while enabled are a whole number of cycles apart
  int edgeN = 0, refN = 0;
  bit haveRef = 0;
  logic prevMode = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      edgeN++;
      if (modeBurst !== prevMode && enable) begin
        if (haveRef) begin
          checks++;
          if (((edgeN - refN) % CYC) != 0) begin
            fails++;
            $display("FAIL R9 mode change spacing: actual %0d expected multiple of %0d",
                     edgeN - refN, CYC);
          end
        end else begin
          haveRef = 1;
          refN = edgeN;
        end
      end
      prevMode = modeBurst;
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    expect4(0, 0, 0, 0, "R1 reset state");
    rst_n = 1'b1;
    waitClk(2);
    expect4(0, 0, 0, 0, "R1 enable low after reset");

    enable = 1'b1; pwmDrive = 1'b1;
    waitClk(2);
    expect4(1, 0, 0, 1, "R2 pwm high phase");
    pwmDrive = 1'b0; #1;
    expect4(0, 1, 0, 1, "R2 pwm low phase");

    // light load with output high: burst idle
    aboveUpper = 1'b1; atTarget = 1'b0; lightLoad = 1'b1;
    waitClk(14);
    expect4(0, 0, 1, 0, "R3 burst entry idle");

    // output falls to target: pulse starts
    aboveUpper = 1'b0; atTarget = 1'b1;
    waitClk(4);
    expect4(1, 0, 1, 1, "R4 pulse start at target");
    peakReached = 1'b1;
    waitClk(4);
    expect4(0, 1, 1, 1, "R5 peak turns high side off");
    peakReached = 1'b0; zeroCurrent = 1'b1;
    waitClk(4);
    expect4(1, 0, 1, 1, "R6 R7 zero current starts next pulse");
    zeroCurrent = 1'b0;

    // upper band during burst: stop after low side
    peakReached = 1'b1;
    waitClk(4);
    peakReached = 1'b0; aboveUpper = 1'b1;
    waitClk(4);
    expect4(0, 1, 1, 1, "R7 low side before stop");
    zeroCurrent = 1'b1;
    waitClk(4);
    zeroCurrent = 1'b0;
    expect4(0, 0, 1, 0, "R7 upper band returns to idle");
    waitClk(6);
    expect4(0, 0, 1, 0, "R4 idle held while above upper");

    // low-side timeout
    aboveUpper = 1'b0;
    waitClk(4);
    peakReached = 1'b1;
    waitClk(4);
    peakReached = 1'b0; aboveUpper = 1'b1;
    waitClk(10);
    expect4(0, 1, 1, 1, "R6 low side held before timeout");
    waitClk(10);
    expect4(0, 0, 1, 0, "R6 timeout ends low side");

    // burst current limit
    aboveUpper = 1'b0;
    waitClk(4);
    expect4(1, 0, 1, 1, "R4 pulse restarts");
    burstLimit = 1'b1;
    waitClk(4);
    expect4(0, 1, 1, 1, "R5 limit ends high side");
    burstLimit = 1'b0; atTarget = 1'b0; zeroCurrent = 1'b1;
    waitClk(4);
    zeroCurrent = 1'b0;
    expect4(0, 0, 1, 0, "R7 limit stops burst");

    // short below-exit pulse must still exit at boundary
    lightLoad = 1'b0;
    belowExit = 1'b1;
    waitClk(2);
    belowExit = 1'b0;
    waitClk(14);
    expect4(0, 1, 0, 1, "R8 pending exit to pwm");

    // light load ignored while below exit
    lightLoad = 1'b1; belowExit = 1'b1;
    waitClk(20);
    expect4(0, 1, 0, 1, "R8 light load blocked by below exit");
    belowExit = 1'b0;
    waitClk(14);
    expect4(0, 0, 1, 0, "R3 re-entry after exit clears");

    // exit collides with running bursts
    atTarget = 1'b1; zeroCurrent = 1'b1; peakReached = 1'b1;
    waitClk(3);
    belowExit = 1'b1;
    waitClk(2);
    belowExit = 1'b0; lightLoad = 1'b0; pwmDrive = 1'b1;
    waitClk(14);
    expect4(1, 0, 0, 1, "R8 exit wins over burst pulses");
    zeroCurrent = 1'b0; peakReached = 1'b0;

    enable = 1'b0;
    waitClk(2);
    expect4(0, 0, 0, 0, "R1 disable forces off");

    waitClk(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule